// File: doc/BRIEF.md
# Extended Address Mode Generator

This block sits beside the fetch and execute logic of an 8051-compatible core that has a 22-bit external address space. It holds the current address-formation scheme in a small mode register. For each instruction it is told about, it works out the external address that the instruction targets, whether the instruction needs one extra machine cycle, and how many address-operand bytes follow the opcode.

The scheme is one of three. The classic scheme gives 8051-identical 16-bit behaviour. The paged scheme keeps 16-bit code unchanged and takes the top address bits from 8-bit extension registers. The contiguous scheme carries wider branch and pointer-load operands. Instruction decode supplies an instruction class, the register values and the already-decoded operand. The results come out registered, one clock after the request.

Top module: `xaddr_gen`

## Requirements
- R1: Writing `mode_wdata` with `mode_we` high sets the mode used by instructions presented from the next cycle on. The codes are 00 classic, 01 paged and 10 contiguous. The code 11 behaves exactly as classic.
- R2: After reset the mode is classic, and `out_valid`, `ext_addr`, `extra_cycle` and `opnd_bytes` are all zero.
- R3: In classic mode, a MOVX through Ri (class 0) gives {P2, Ri}, where `ri_sel`=1 picks R1. A MOVX through a data pointer (class 1) gives {DPH, DPL} of the pointer picked by `dp_sel`. Address bits 21:16 are zero for every result in classic mode.
- R4: In paged and contiguous modes, a MOVX through Ri gives {movx_ext[5:0], P2, Ri}.
- R5: In paged and contiguous modes, a data-pointer MOVX gives {dpx[5:0], DPH, DPL} of the selected pointer. P2 and `movx_ext` have no effect on it.
- R6: `extra_cycle` is 1 only in paged or contiguous mode, and only for ACALL (2), LCALL (4), RET (6), RETI (7) and interrupt entry (9).
- R7: `opnd_bytes` in classic and paged modes is 1 for ACALL and AJMP (3), 2 for LCALL, LJMP (5) and pointer load (8), and 0 otherwise. In contiguous mode it is 2 for ACALL and AJMP, 3 for LCALL, LJMP and pointer load, and 0 otherwise.
- R8: Branch targets are built as follows. LCALL and LJMP give opnd[15:0] in classic mode, {page[5:0], opnd[15:0]} in paged mode and opnd[21:0] in contiguous mode. ACALL and AJMP give {pc_next[15:11], opnd[10:0]} in classic mode (upper bits zero), the same with page[5:0] on top in paged mode, and {pc_next[21:19], opnd[18:0]} in contiguous mode.
- R9: RET and RETI give opnd[15:0] in classic mode and opnd[21:0] otherwise. Pointer load gives opnd[21:0] in contiguous mode and opnd[15:0] otherwise. Interrupt entry gives opnd[15:0] in all modes. Class codes 10 to 15 give address 0, no extra cycle and 0 operand bytes.
- R10: `out_valid` equals `instr_valid` of the previous cycle. While `out_valid` is 0, the other outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode code to write |
| instr_valid | input | 1 | Instruction request present |
| instr_class | input | 4 | Instruction class code |
| ri_sel | input | 1 | 0 picks R0, 1 picks R1 |
| dp_sel | input | 1 | Data pointer select |
| p2 | input | 8 | Port 2 register value |
| r0 | input | 8 | R0 value |
| r1 | input | 8 | R1 value |
| dph | input | 16 | High bytes of both data pointers (pointer 0 in bits 7:0) |
| dpl | input | 16 | Low bytes of both data pointers |
| dpx | input | 16 | Extension bytes of both data pointers |
| page_reg | input | 8 | Address page register |
| movx_ext | input | 8 | MOVX extension register |
| pc_next | input | 22 | Address of the following instruction |
| opnd | input | 24 | Decoded address operand or popped return address |
| out_valid | output | 1 | Result valid |
| ext_addr | output | 22 | Formed external address |
| extra_cycle | output | 1 | One extra machine cycle needed |
| opnd_bytes | output | 2 | Address-operand byte count |

## Verification
On every cycle, the assertions check these properties: a classic-mode result has zeroed upper address bits and no extra cycle; the stack-touching classes always carry the extra cycle outside classic mode; a three-byte operand appears only in contiguous mode; a data-pointer MOVX outside classic mode takes its top bits from the selected extension byte; and the valid flag trails the request by one cycle. Only the bench's sweeps can show the exact concatenation for each class and mode, the aliasing of code 11 onto classic, the immunity of the pointer MOVX to P2 and the MOVX extension, and the return to classic after a reset taken in contiguous mode.

// File: rtl/xaddr_pkg.sv
package xaddr_pkg;

    typedef enum logic [1:0] {
        MODE_16     = 2'd0,
        MODE_PAGED  = 2'd1,
        MODE_CONTIG = 2'd2
    } mode_e;

    typedef enum logic [3:0] {
        CL_MOVX_RI = 4'd0,
        CL_MOVX_DP = 4'd1,
        CL_ACALL   = 4'd2,
        CL_AJMP    = 4'd3,
        CL_LCALL   = 4'd4,
        CL_LJMP    = 4'd5,
        CL_RET     = 4'd6,
        CL_RETI    = 4'd7,
        CL_DPLOAD  = 4'd8,
        CL_INTR    = 4'd9
    } iclass_e;

    function automatic mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b01:   return MODE_PAGED;
            2'b10:   return MODE_CONTIG;
            default: return MODE_16;
        endcase
    endfunction

endpackage

// File: rtl/xaddr_mode_reg.sv
module xaddr_mode_reg
    import xaddr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] wdata,
    output mode_e      mode_q
);
    mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (we) begin
            mode_d = decode_mode(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_16;
        end else begin
            mode_q <= mode_d;
        end
    end
endmodule

// File: rtl/xaddr_dp_mux.sv
module xaddr_dp_mux #(
    parameter int NUM_DP = 2,
    parameter int BYTE_W = 8,
    localparam int DPS_W = (NUM_DP > 1) ? $clog2(NUM_DP) : 1
) (
    input  logic [NUM_DP*BYTE_W-1:0] dph_all,
    input  logic [NUM_DP*BYTE_W-1:0] dpl_all,
    input  logic [NUM_DP*BYTE_W-1:0] dpx_all,
    input  logic [DPS_W-1:0]         sel,
    output logic [BYTE_W-1:0]        dph_o,
    output logic [BYTE_W-1:0]        dpl_o,
    output logic [BYTE_W-1:0]        dpx_o
);
    logic [BYTE_W-1:0] dph_arr [NUM_DP];
    logic [BYTE_W-1:0] dpl_arr [NUM_DP];
    logic [BYTE_W-1:0] dpx_arr [NUM_DP];

    for (genvar g = 0; g < NUM_DP; g++) begin : g_unpack
        assign dph_arr[g] = dph_all[g*BYTE_W +: BYTE_W];
        assign dpl_arr[g] = dpl_all[g*BYTE_W +: BYTE_W];
        assign dpx_arr[g] = dpx_all[g*BYTE_W +: BYTE_W];
    end

    assign dph_o = dph_arr[sel];
    assign dpl_o = dpl_arr[sel];
    assign dpx_o = dpx_arr[sel];
endmodule

// File: rtl/xaddr_form.sv
module xaddr_form
    import xaddr_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int OPND_W   = 24,
    parameter int SHORT_W  = 11,
    parameter int CSHORT_W = 19,
    localparam int HI_W    = ADDR_W - 16
) (
    input  mode_e              mode,
    input  logic [3:0]         cls,
    input  logic               ri_sel,
    input  logic [7:0]         p2,
    input  logic [7:0]         r0,
    input  logic [7:0]         r1,
    input  logic [7:0]         dph_s,
    input  logic [7:0]         dpl_s,
    input  logic [7:0]         dpx_s,
    input  logic [7:0]         page_reg,
    input  logic [7:0]         movx_ext,
    input  logic [ADDR_W-1:0]  pc_next,
    input  logic [OPND_W-1:0]  opnd,
    output logic [ADDR_W-1:0]  addr
);
    localparam logic [HI_W-1:0] ZHI = '0;

    logic [7:0]      ri;
    logic [HI_W-1:0] hi_page;
    logic [HI_W-1:0] hi_br;
    logic            classic;
    logic            contig;
    logic            unused_bits;

    assign unused_bits = ^{pc_next[CSHORT_W-1:16], pc_next[SHORT_W-1:0],
                           opnd[OPND_W-1:ADDR_W], page_reg[7:HI_W],
                           movx_ext[7:HI_W], dpx_s[7:HI_W]};

    always_comb begin
        ri      = ri_sel ? r1 : r0;
        classic = (mode == MODE_16);
        contig  = (mode == MODE_CONTIG);
        hi_page = page_reg[HI_W-1:0];
        hi_br   = classic ? ZHI : hi_page;
        addr    = '0;
        case (iclass_e'(cls))
            CL_MOVX_RI: begin
                addr = classic ? {ZHI, p2, ri} : {movx_ext[HI_W-1:0], p2, ri};
            end
            CL_MOVX_DP: begin
                addr = classic ? {ZHI, dph_s, dpl_s} : {dpx_s[HI_W-1:0], dph_s, dpl_s};
            end
            CL_ACALL, CL_AJMP: begin
                if (contig) begin
                    addr = {pc_next[ADDR_W-1:CSHORT_W], opnd[CSHORT_W-1:0]};
                end else begin
                    addr = {hi_br, pc_next[15:SHORT_W], opnd[SHORT_W-1:0]};
                end
            end
            CL_LCALL, CL_LJMP: begin
                addr = contig ? opnd[ADDR_W-1:0] : {hi_br, opnd[15:0]};
            end
            CL_RET, CL_RETI: begin
                addr = classic ? {ZHI, opnd[15:0]} : opnd[ADDR_W-1:0];
            end
            CL_DPLOAD: begin
                addr = contig ? opnd[ADDR_W-1:0] : {ZHI, opnd[15:0]};
            end
            CL_INTR: begin
                addr = {ZHI, opnd[15:0]};
            end
            default: begin
                addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/xaddr_timing.sv
module xaddr_timing
    import xaddr_pkg::*;
(
    input  mode_e      mode,
    input  logic [3:0] cls,
    output logic       extra,
    output logic [1:0] nbytes
);
    logic stack_cls;
    logic contig;

    always_comb begin
        contig    = (mode == MODE_CONTIG);
        stack_cls = 1'b0;
        nbytes    = 2'd0;
        case (iclass_e'(cls))
            CL_ACALL: begin
                stack_cls = 1'b1;
                nbytes    = contig ? 2'd2 : 2'd1;
            end
            CL_AJMP: begin
                nbytes = contig ? 2'd2 : 2'd1;
            end
            CL_LCALL: begin
                stack_cls = 1'b1;
                nbytes    = contig ? 2'd3 : 2'd2;
            end
            CL_LJMP, CL_DPLOAD: begin
                nbytes = contig ? 2'd3 : 2'd2;
            end
            CL_RET, CL_RETI, CL_INTR: begin
                stack_cls = 1'b1;
            end
            default: begin
                nbytes = 2'd0;
            end
        endcase
        extra = stack_cls && (mode != MODE_16);
    end
endmodule

// File: rtl/xaddr_gen.sv
module xaddr_gen
    import xaddr_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int OPND_W   = 24,
    parameter int NUM_DP   = 2,
    parameter int SHORT_W  = 11,
    parameter int CSHORT_W = 19,
    localparam int DPS_W   = (NUM_DP > 1) ? $clog2(NUM_DP) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_we,
    input  logic [1:0]          mode_wdata,
    input  logic                instr_valid,
    input  logic [3:0]          instr_class,
    input  logic                ri_sel,
    input  logic [DPS_W-1:0]    dp_sel,
    input  logic [7:0]          p2,
    input  logic [7:0]          r0,
    input  logic [7:0]          r1,
    input  logic [NUM_DP*8-1:0] dph,
    input  logic [NUM_DP*8-1:0] dpl,
    input  logic [NUM_DP*8-1:0] dpx,
    input  logic [7:0]          page_reg,
    input  logic [7:0]          movx_ext,
    input  logic [ADDR_W-1:0]   pc_next,
    input  logic [OPND_W-1:0]   opnd,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   ext_addr,
    output logic                extra_cycle,
    output logic [1:0]          opnd_bytes
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic              extra;
        logic [1:0]        nbytes;
    } res_t;

    mode_e             mode_q;
    logic [7:0]        dph_s, dpl_s, dpx_s;
    logic [ADDR_W-1:0] addr_c;
    logic              extra_c;
    logic [1:0]        nbytes_c;
    res_t              res_d, res_q;

    xaddr_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mode_we),
        .wdata  (mode_wdata),
        .mode_q (mode_q)
    );

    xaddr_dp_mux #(.NUM_DP(NUM_DP), .BYTE_W(8)) u_dpmux (
        .dph_all (dph),
        .dpl_all (dpl),
        .dpx_all (dpx),
        .sel     (dp_sel),
        .dph_o   (dph_s),
        .dpl_o   (dpl_s),
        .dpx_o   (dpx_s)
    );

    xaddr_form #(
        .ADDR_W(ADDR_W), .OPND_W(OPND_W),
        .SHORT_W(SHORT_W), .CSHORT_W(CSHORT_W)
    ) u_form (
        .mode     (mode_q),
        .cls      (instr_class),
        .ri_sel   (ri_sel),
        .p2       (p2),
        .r0       (r0),
        .r1       (r1),
        .dph_s    (dph_s),
        .dpl_s    (dpl_s),
        .dpx_s    (dpx_s),
        .page_reg (page_reg),
        .movx_ext (movx_ext),
        .pc_next  (pc_next),
        .opnd     (opnd),
        .addr     (addr_c)
    );

    xaddr_timing u_timing (
        .mode   (mode_q),
        .cls    (instr_class),
        .extra  (extra_c),
        .nbytes (nbytes_c)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = instr_valid;
        if (instr_valid) begin
            res_d.addr   = addr_c;
            res_d.extra  = extra_c;
            res_d.nbytes = nbytes_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.vld;
    assign ext_addr    = res_q.addr;
    assign extra_cycle = res_q.extra;
    assign opnd_bytes  = res_q.nbytes;
endmodule

// File: rtl/xaddr_gen_chk.sv
module xaddr_gen_chk
    import xaddr_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int NUM_DP = 2,
    localparam int DPS_W = (NUM_DP > 1) ? $clog2(NUM_DP) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input mode_e               mode_q,
    input logic                instr_valid,
    input logic [3:0]          instr_class,
    input logic [DPS_W-1:0]    dp_sel,
    input logic [NUM_DP*8-1:0] dpx,
    input logic                out_valid,
    input logic [ADDR_W-1:0]   ext_addr,
    input logic                extra_cycle,
    input logic [1:0]          opnd_bytes
);
    logic [7:0] dpx_pick;
    logic       stack_cls;

    assign dpx_pick  = dpx[dp_sel*8 +: 8];
    assign stack_cls = (instr_class == 4'd2) || (instr_class == 4'd4) ||
                       (instr_class == 4'd6) || (instr_class == 4'd7) ||
                       (instr_class == 4'd9);

    a_r2_mode_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_q == MODE_16));

    a_r3_classic_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode_q) == MODE_16) |-> (ext_addr[ADDR_W-1:16] == '0));

    a_r6_classic_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode_q) == MODE_16) |-> !extra_cycle);

    a_r6_stack_extra: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode_q) != MODE_16 && $past(stack_cls)) |-> extra_cycle);

    a_r7_three_only_contig: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && opnd_bytes == 2'd3) |-> ($past(mode_q) == MODE_CONTIG));

    a_r5_dp_ext_top: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode_q) != MODE_16 && $past(instr_class) == 4'd1)
        |-> (ext_addr[ADDR_W-1:16] == $past(dpx_pick[ADDR_W-17:0])));

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> out_valid);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && out_valid) |=> (!out_valid && $stable(ext_addr)));
endmodule

bind xaddr_gen xaddr_gen_chk #(.ADDR_W(ADDR_W), .NUM_DP(NUM_DP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_q      (mode_q),
    .instr_valid (instr_valid),
    .instr_class (instr_class),
    .dp_sel      (dp_sel),
    .dpx         (dpx),
    .out_valid   (out_valid),
    .ext_addr    (ext_addr),
    .extra_cycle (extra_cycle),
    .opnd_bytes  (opnd_bytes)
);

// File: tb/xaddr_gen_bench.sv
module xaddr_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_we;
    logic [1:0]  mode_wdata;
    logic        instr_valid;
    logic [3:0]  instr_class;
    logic        ri_sel;
    logic [0:0]  dp_sel;
    logic [7:0]  p2, r0, r1, page_reg, movx_ext;
    logic [15:0] dph, dpl, dpx;
    logic [21:0] pc_next;
    logic [23:0] opnd;
    logic        out_valid;
    logic [21:0] ext_addr;
    logic        extra_cycle;
    logic [1:0]  opnd_bytes;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xaddr_gen u_xaddr_gen (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .instr_valid(instr_valid), .instr_class(instr_class), .ri_sel(ri_sel),
        .dp_sel(dp_sel), .p2(p2), .r0(r0), .r1(r1), .dph(dph), .dpl(dpl),
        .dpx(dpx), .page_reg(page_reg), .movx_ext(movx_ext), .pc_next(pc_next),
        .opnd(opnd), .out_valid(out_valid), .ext_addr(ext_addr),
        .extra_cycle(extra_cycle), .opnd_bytes(opnd_bytes)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected address, built only from the requirement text.
    function automatic logic [21:0] exp_addr(input int m, input int c);
        logic [7:0]  ri, h, l, x;
        logic [5:0]  pg;
        ri = ri_sel ? r1 : r0;
        h  = dp_sel[0] ? dph[15:8] : dph[7:0];
        l  = dp_sel[0] ? dpl[15:8] : dpl[7:0];
        x  = dp_sel[0] ? dpx[15:8] : dpx[7:0];
        pg = (m == 1) ? page_reg[5:0] : 6'd0;
        case (c)
            0: return (m == 0) ? {6'd0, p2, ri} : {movx_ext[5:0], p2, ri};
            1: return (m == 0) ? {6'd0, h, l} : {x[5:0], h, l};
            2, 3: return (m == 2) ? {pc_next[21:19], opnd[18:0]}
                                  : {pg, pc_next[15:11], opnd[10:0]};
            4, 5: return (m == 2) ? opnd[21:0] : {pg, opnd[15:0]};
            6, 7: return (m == 0) ? {6'd0, opnd[15:0]} : opnd[21:0];
            8: return (m == 2) ? opnd[21:0] : {6'd0, opnd[15:0]};
            9: return {6'd0, opnd[15:0]};
            default: return 22'd0;
        endcase
    endfunction

    function automatic logic exp_extra(input int m, input int c);
        return (m != 0) && (c == 2 || c == 4 || c == 6 || c == 7 || c == 9);
    endfunction

    function automatic logic [1:0] exp_bytes(input int m, input int c);
        if (c == 2 || c == 3) return (m == 2) ? 2'd2 : 2'd1;
        if (c == 4 || c == 5 || c == 8) return (m == 2) ? 2'd3 : 2'd2;
        return 2'd0;
    endfunction

    function automatic string addr_tag(input int wcode, input int c);
        if (wcode == 3) return "R1";
        if (c == 0) return (wcode == 0) ? "R3" : "R4";
        if (c == 1) return (wcode == 0) ? "R3" : "R5";
        if (c >= 2 && c <= 5) return "R8";
        return "R9";
    endfunction

    task automatic set_pattern(input int p);
        ri_sel   = p[0];
        dp_sel   = p[1:1] ^ p[0:0];
        p2       = 8'hA5 + 8'(p * 8'h17);
        r0       = 8'h3C ^ 8'(p * 8'h29);
        r1       = 8'hC3 + 8'(p * 8'h0B);
        dph      = 16'h12E8 + 16'(p * 16'h1357);
        dpl      = 16'h47B1 ^ 16'(p * 16'h2468);
        dpx      = 16'hF2A9 - 16'(p * 16'h0F1E);
        page_reg = 8'hE6 ^ 8'(p * 8'h15);
        movx_ext = 8'h9B + 8'(p * 8'h31);
        pc_next  = 22'h2A5F3C ^ 22'(p * 22'h13579B);
        opnd     = 24'hD6B7E5 + 24'(p * 24'h2468AC);
    endtask

    task automatic write_mode(input logic [1:0] code);
        @(negedge clk);
        mode_we    = 1'b1;
        mode_wdata = code;
        instr_valid = 1'b0;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic run_instr(input int wcode, input int c, input int m);
        logic [21:0] ea;
        logic        ee;
        logic [1:0]  eb;
        instr_valid = 1'b1;
        instr_class = 4'(c);
        ea = exp_addr(m, c);
        ee = exp_extra(m, c);
        eb = exp_bytes(m, c);
        @(negedge clk);
        check("R10", "out_valid", 32'(out_valid), 32'd1);
        check(addr_tag(wcode, c), "ext_addr", 32'(ext_addr), 32'(ea));
        check((wcode == 3) ? "R1" : "R6", "extra_cycle", 32'(extra_cycle), 32'(ee));
        check((wcode == 3) ? "R1" : "R7", "opnd_bytes", 32'(opnd_bytes), 32'(eb));
    endtask

    initial begin
        rst_n = 1'b0; mode_we = 1'b0; mode_wdata = 2'd0;
        instr_valid = 1'b0; instr_class = 4'd0;
        set_pattern(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "out_valid after reset", 32'(out_valid), 32'd0);
        check("R2", "ext_addr after reset", 32'(ext_addr), 32'd0);
        check("R2", "extra_cycle after reset", 32'(extra_cycle), 32'd0);
        check("R2", "opnd_bytes after reset", 32'(opnd_bytes), 32'd0);
        // Default mode must be classic: upper bits zero on a paged-style MOVX.
        run_instr(0, 0, 0);

        for (int w = 0; w < 4; w++) begin
            write_mode(2'(w));
            for (int p = 0; p < 3; p++) begin
                set_pattern(p + w);
                for (int c = 0; c < 16; c++) begin
                    run_instr(w, c, (w == 3) ? 0 : w);
                end
            end
        end

        // R5: P2 and MOVX extension changes leave a pointer MOVX unchanged.
        write_mode(2'b01);
        set_pattern(5);
        run_instr(1, 1, 1);
        p2 = ~p2; movx_ext = ~movx_ext;
        run_instr(1, 1, 1);

        // R10: idle cycle drops valid and holds the rest.
        begin
            logic [21:0] held;
            held = ext_addr;
            instr_valid = 1'b0;
            instr_class = 4'd5;
            opnd = ~opnd;
            @(negedge clk);
            check("R10", "out_valid idle", 32'(out_valid), 32'd0);
            check("R10", "ext_addr held", 32'(ext_addr), 32'(held));
            check("R10", "opnd_bytes held", 32'(opnd_bytes), 32'd0);
        end

        // R2: reset taken in contiguous mode returns to classic.
        write_mode(2'b10);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        set_pattern(7);
        run_instr(0, 4, 0);
        check("R2", "classic after reset, ext_addr hi", 32'(ext_addr[21:16]), 32'd0);

        instr_valid = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule